// File: doc/BRIEF.md
# Pointer Address Generation Unit

This block turns one of three 16-bit pointers into a data-memory address or a jump target. It also computes the updated pointer value for the register file to write back. Each pointer is stored as a pair of 8-bit general registers. The register file supplies the current values of all three pairs. The instruction decoder supplies a pointer select, a 3-bit operation code and a 6-bit unsigned immediate.

The unit supports the following operations:
- plain indirect access;
- access that bumps the pointer up by one after use;
- access that steps the pointer down by one before use;
- access at the pointer plus a displacement of 0 to 63, with the pointer left unchanged;
- one-cycle addition of a constant of 0 to 63 to the pointer;
- one-cycle subtraction of such a constant from the pointer;
- routing the pointer out as the target of an indirect jump or call.

All arithmetic wraps modulo 2^16. Results are registered, so they appear one clock after the request. The asynchronous active-low reset is released synchronously through a two-stage synchronizer inside the block.

Top module: `ptr_agu`

## Requirements
- R1: While reset is asserted, and for the two clocks after its release, `mem_en`, `jmp_en`, `wb_lo_we` and `wb_hi_we` are low.
- R2: Operation code 0 (plain) gives `mem_en`=1 and `eff_addr` equal to the pointer, with no write-back.
- R3: Operation code 1 (post-increment) gives `eff_addr` equal to the original pointer, with the pointer plus one (mod 2^16) written back.
- R4: Operation code 2 (pre-decrement) gives `eff_addr` equal to the pointer minus one (mod 2^16), with that same value written back.
- R5: Operation code 3 (displacement) gives `eff_addr` equal to the pointer plus `imm` (0 to 63, mod 2^16), with no write-back.
- R6: Operation code 4 (add constant) writes back the pointer plus `imm` (mod 2^16), with `mem_en` and `jmp_en` low.
- R7: Operation code 5 (subtract constant) writes back the pointer minus `imm` (mod 2^16), with `mem_en` and `jmp_en` low.
- R8: Operation code 6 (jump target) gives `jmp_en`=1 and `eff_addr` equal to the pointer, with `mem_en` low and no write-back.
- R9: Select 0, 1 and 2 pick register pairs 26/27, 28/29 and 30/31. The pair for select k sits at `ptr_file[16k+15:16k]`, with the low byte at the low bits and in the even register. On a write-back, both byte enables are high in the same cycle, `wb_lo_idx` is even and `wb_hi_idx` equals `wb_lo_idx`+1.
- R10: Every output reflects the request presented on the previous clock. A clock with `req_valid` low leaves all enables low on the next cycle.
- R11: A request with select 3 or operation code 7 is ignored: on the next cycle all enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| ptr_sel | input | 2 | Pointer select (0..2) |
| op | input | 3 | Operation code |
| imm | input | 6 | Displacement or constant, unsigned |
| ptr_file | input | 48 | Current values of the three pointer pairs |
| mem_en | output | 1 | Data-memory access at eff_addr |
| jmp_en | output | 1 | eff_addr is a jump or call target |
| eff_addr | output | 16 | Effective address |
| wb_lo_we | output | 1 | Write enable, pointer low byte |
| wb_hi_we | output | 1 | Write enable, pointer high byte |
| wb_lo_idx | output | 5 | Register index of the low byte |
| wb_hi_idx | output | 5 | Register index of the high byte |
| wb_lo_data | output | 8 | New low byte |
| wb_hi_data | output | 8 | New high byte |

## Verification
A wrong operand, a wrong carry or borrow, or a wrong pair selection shows up in `eff_addr` or in the write-back bytes and indices on the very next cycle. This is because there is only one register stage. The bench therefore compares every field after each single request. It drives pointers next to 0x0000 and 0xFFFF and the immediate at 63, so that wrap and carry faults in the high byte are exposed. Enables that stay high and leak from one operation into the next are caught by idle and ignored requests placed between live ones.

// File: rtl/ptr_agu_pkg.sv
package ptr_agu_pkg;
  localparam int PTR_W  = 16;
  localparam int BYTE_W = 8;
  localparam int IMM_W  = 6;
  localparam int RIDX_W = 5;

  typedef enum logic [2:0] {
    OP_PLAIN   = 3'd0,
    OP_POSTINC = 3'd1,
    OP_PREDEC  = 3'd2,
    OP_DISP    = 3'd3,
    OP_ADDK    = 3'd4,
    OP_SUBK    = 3'd5,
    OP_JUMP    = 3'd6,
    OP_NONE    = 3'd7
  } agu_op_e;

  typedef struct packed {
    logic              mem_en;
    logic              jmp_en;
    logic              wb_en;
    logic [PTR_W-1:0]  addr;
    logic [PTR_W-1:0]  wb_val;
    logic [RIDX_W-1:0] lo_idx;
  } agu_res_t;
endpackage

// File: rtl/ptr_sel_mux.sv
module ptr_sel_mux
  import ptr_agu_pkg::*;
#(
  parameter int NPTR     = 3,
  parameter int BASE_REG = 26,
  parameter int SEL_W    = 2
) (
  input  logic [NPTR*PTR_W-1:0] ptr_file,
  input  logic [SEL_W-1:0]      sel,
  output logic [PTR_W-1:0]      ptr_val,
  output logic [RIDX_W-1:0]     lo_idx,
  output logic                  sel_ok
);
  logic [PTR_W-1:0]  pair  [NPTR];
  logic [RIDX_W-1:0] pidx  [NPTR];

  for (genvar g = 0; g < NPTR; g++) begin : g_pair
    assign pair[g] = ptr_file[g*PTR_W +: PTR_W];
    assign pidx[g] = RIDX_W'(BASE_REG + 2*g);
  end

  always_comb begin
    ptr_val = '0;
    lo_idx  = '0;
    sel_ok  = 1'b0;
    for (int i = 0; i < NPTR; i++) begin
      if (sel == SEL_W'(i)) begin
        ptr_val = pair[i];
        lo_idx  = pidx[i];
        sel_ok  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/ptr_arith.sv
module ptr_arith
  import ptr_agu_pkg::*;
(
  input  logic              req,
  input  logic              sel_ok,
  input  logic [2:0]        op,
  input  logic [IMM_W-1:0]  imm,
  input  logic [PTR_W-1:0]  ptr,
  input  logic [RIDX_W-1:0] lo_idx,
  output agu_res_t          res
);
  logic [PTR_W-1:0] imm_ext;
  logic [PTR_W-1:0] sum;
  logic [PTR_W-1:0] dif;
  logic             live;

  assign imm_ext = PTR_W'(imm);
  assign live    = req && sel_ok;

  always_comb begin
    sum = ptr + imm_ext;
    dif = ptr - imm_ext;
    res = '0;
    res.lo_idx = lo_idx;
    if (live) begin
      unique case (agu_op_e'(op))
        OP_PLAIN:   begin res.mem_en = 1'b1; res.addr = ptr; end
        OP_POSTINC: begin res.mem_en = 1'b1; res.addr = ptr;
                          res.wb_en = 1'b1; res.wb_val = ptr + PTR_W'(1); end
        OP_PREDEC:  begin res.mem_en = 1'b1; res.addr = ptr - PTR_W'(1);
                          res.wb_en = 1'b1; res.wb_val = ptr - PTR_W'(1); end
        OP_DISP:    begin res.mem_en = 1'b1; res.addr = sum; end
        OP_ADDK:    begin res.wb_en = 1'b1; res.wb_val = sum; end
        OP_SUBK:    begin res.wb_en = 1'b1; res.wb_val = dif; end
        OP_JUMP:    begin res.jmp_en = 1'b1; res.addr = ptr; end
        default:    res = '0;
      endcase
    end
  end
endmodule

// File: rtl/ptr_out_reg.sv
module ptr_out_reg
  import ptr_agu_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  agu_res_t d,
  output agu_res_t q
);
  logic     load;
  agu_res_t q_nxt;

  assign load = d.mem_en | d.jmp_en | d.wb_en;

  always_comb begin
    q_nxt        = q;
    q_nxt.mem_en = d.mem_en;
    q_nxt.jmp_en = d.jmp_en;
    q_nxt.wb_en  = d.wb_en;
    if (load) begin
      q_nxt.addr   = d.addr;
      q_nxt.wb_val = d.wb_val;
      q_nxt.lo_idx = d.lo_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/ptr_agu.sv
module ptr_agu
  import ptr_agu_pkg::*;
#(
  parameter int NPTR     = 3,
  parameter int BASE_REG = 26,
  parameter int SEL_W    = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic [SEL_W-1:0]      ptr_sel,
  input  logic [2:0]            op,
  input  logic [IMM_W-1:0]      imm,
  input  logic [NPTR*PTR_W-1:0] ptr_file,
  output logic                  mem_en,
  output logic                  jmp_en,
  output logic [PTR_W-1:0]      eff_addr,
  output logic                  wb_lo_we,
  output logic                  wb_hi_we,
  output logic [RIDX_W-1:0]     wb_lo_idx,
  output logic [RIDX_W-1:0]     wb_hi_idx,
  output logic [BYTE_W-1:0]     wb_lo_data,
  output logic [BYTE_W-1:0]     wb_hi_data
);
  logic [1:0]        rst_sync;
  logic              rst_int_n;
  logic [PTR_W-1:0]  sel_ptr;
  logic [RIDX_W-1:0] sel_idx;
  logic              sel_ok;
  agu_res_t          res_c;
  agu_res_t          res_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  ptr_sel_mux #(.NPTR(NPTR), .BASE_REG(BASE_REG), .SEL_W(SEL_W)) u_mux (
    .ptr_file(ptr_file), .sel(ptr_sel), .ptr_val(sel_ptr),
    .lo_idx(sel_idx), .sel_ok(sel_ok)
  );

  ptr_arith u_arith (
    .req(req_valid), .sel_ok(sel_ok), .op(op), .imm(imm),
    .ptr(sel_ptr), .lo_idx(sel_idx), .res(res_c)
  );

  ptr_out_reg u_reg (.clk(clk), .rst_n(rst_int_n), .d(res_c), .q(res_q));

  assign mem_en     = res_q.mem_en;
  assign jmp_en     = res_q.jmp_en;
  assign eff_addr   = res_q.addr;
  assign wb_lo_we   = res_q.wb_en;
  assign wb_hi_we   = res_q.wb_en;
  assign wb_lo_idx  = res_q.lo_idx;
  assign wb_hi_idx  = res_q.lo_idx | RIDX_W'(1);
  assign wb_lo_data = res_q.wb_val[BYTE_W-1:0];
  assign wb_hi_data = res_q.wb_val[PTR_W-1:BYTE_W];

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_int_n |-> !(mem_en || jmp_en || wb_lo_we || wb_hi_we));

  a_r10_idle: assert property (@(posedge clk) disable iff (!rst_int_n)
    !req_valid |=> !(mem_en || jmp_en || wb_lo_we));

  a_r11_ignored: assert property (@(posedge clk) disable iff (!rst_int_n)
    (req_valid && (ptr_sel >= SEL_W'(NPTR) || op == 3'd7))
    |=> !(mem_en || jmp_en || wb_lo_we));

  a_r3_postinc: assert property (@(posedge clk) disable iff (!rst_int_n)
    (req_valid && sel_ok && op == 3'd1)
    |=> {wb_hi_data, wb_lo_data} == eff_addr + PTR_W'(1) && eff_addr == $past(sel_ptr));

  a_r4_predec: assert property (@(posedge clk) disable iff (!rst_int_n)
    (req_valid && sel_ok && op == 3'd2)
    |=> {wb_hi_data, wb_lo_data} == eff_addr && eff_addr == $past(sel_ptr) - PTR_W'(1));

  a_r5_disp: assert property (@(posedge clk) disable iff (!rst_int_n)
    (req_valid && sel_ok && op == 3'd3)
    |=> mem_en && !wb_lo_we && eff_addr == $past(sel_ptr) + PTR_W'($past(imm)));

  a_r8_jump: assert property (@(posedge clk) disable iff (!rst_int_n)
    (req_valid && sel_ok && op == 3'd6) |=> jmp_en && !mem_en && !wb_lo_we);

  a_r9_pair: assert property (@(posedge clk) disable iff (!rst_int_n)
    wb_lo_we |-> wb_hi_we && !wb_lo_idx[0] && wb_hi_idx == wb_lo_idx + RIDX_W'(1));
endmodule

// File: tb/ptr_agu_test.sv
module ptr_agu_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [1:0]  ptr_sel;
  logic [2:0]  op;
  logic [5:0]  imm;
  logic [47:0] ptr_file;
  logic        mem_en, jmp_en, wb_lo_we, wb_hi_we;
  logic [15:0] eff_addr;
  logic [4:0]  wb_lo_idx, wb_hi_idx;
  logic [7:0]  wb_lo_data, wb_hi_data;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ptr_agu uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .ptr_sel(ptr_sel),
    .op(op), .imm(imm), .ptr_file(ptr_file), .mem_en(mem_en),
    .jmp_en(jmp_en), .eff_addr(eff_addr), .wb_lo_we(wb_lo_we),
    .wb_hi_we(wb_hi_we), .wb_lo_idx(wb_lo_idx), .wb_hi_idx(wb_hi_idx),
    .wb_lo_data(wb_lo_data), .wb_hi_data(wb_hi_data)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input bit v, input logic [1:0] s, input logic [2:0] o);
    if (!v) return "R10";
    if (s == 2'd3 || o == 3'd7) return "R11";
    case (o)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      3'd5: return "R7";
      default: return "R8";
    endcase
  endfunction

  function automatic void model(input bit v, input logic [1:0] s, input logic [2:0] o,
                                input logic [5:0] k, input logic [47:0] f,
                                output bit m, output bit j, output bit w,
                                output logic [15:0] a, output logic [15:0] wv,
                                output logic [4:0] li);
    logic [15:0] p;
    m = 0; j = 0; w = 0; a = 0; wv = 0; li = 0;
    if (!v || s == 2'd3 || o == 3'd7) return;
    p  = f[s*16 +: 16];
    li = 5'd26 + 5'(2*s);
    case (o)
      3'd0: begin m = 1; a = p; end
      3'd1: begin m = 1; a = p; w = 1; wv = p + 16'd1; end
      3'd2: begin m = 1; a = p - 16'd1; w = 1; wv = p - 16'd1; end
      3'd3: begin m = 1; a = p + {10'd0, k}; end
      3'd4: begin w = 1; wv = p + {10'd0, k}; end
      3'd5: begin w = 1; wv = p - {10'd0, k}; end
      default: begin j = 1; a = p; end
    endcase
  endfunction

  task automatic do_req(input bit v, input logic [1:0] s, input logic [2:0] o,
                        input logic [5:0] k, input logic [47:0] f);
    bit m, j, w;
    logic [15:0] a, wv;
    logic [4:0] li;
    string t;
    req_valid = v; ptr_sel = s; op = o; imm = k; ptr_file = f;
    model(v, s, o, k, f, m, j, w, a, wv, li);
    t = tag_of(v, s, o);
    @(posedge clk);
    @(negedge clk);
    check({mem_en, jmp_en, wb_lo_we, wb_hi_we} == {m, j, w, w}, t,
          {mem_en, jmp_en, wb_lo_we, wb_hi_we}, {m, j, w, w});
    if (m || j) check(eff_addr == a, t, eff_addr, a);
    if (w) begin
      check({wb_hi_data, wb_lo_data} == wv, t, {wb_hi_data, wb_lo_data}, wv);
      // R9: pair indices, low byte even
      check(wb_lo_idx == li && wb_hi_idx == li + 5'd1, "R9",
            {wb_hi_idx, wb_lo_idx}, {li + 5'd1, li});
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; req_valid = 1'b1; ptr_sel = 0; op = 0; imm = 0; ptr_file = '1;
    repeat (3) @(negedge clk);
    // R1: quiet in reset even with a live request
    check({mem_en, jmp_en, wb_lo_we, wb_hi_we} == 4'b0, "R1",
          {mem_en, jmp_en, wb_lo_we, wb_hi_we}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check({mem_en, jmp_en, wb_lo_we, wb_hi_we} == 4'b0, "R1",
          {mem_en, jmp_en, wb_lo_we, wb_hi_we}, 0);
    @(negedge clk);
    check({mem_en, jmp_en, wb_lo_we, wb_hi_we} == 4'b0, "R1",
          {mem_en, jmp_en, wb_lo_we, wb_hi_we}, 0);

    // Directed corners: wrap, max displacement, every pair
    do_req(1, 2'd0, 3'd1, 6'd0,  {16'h1111, 16'h2222, 16'hFFFF}); // R3 wrap up
    do_req(1, 2'd1, 3'd2, 6'd0,  {16'h1111, 16'h0000, 16'h3333}); // R4 wrap down
    do_req(1, 2'd2, 3'd3, 6'd63, {16'hFFF0, 16'h0000, 16'h0000}); // R5 max disp, wrap
    do_req(0, 2'd2, 3'd1, 6'd5,  {16'h1234, 16'h0000, 16'h0000}); // R10 idle
    do_req(1, 2'd0, 3'd4, 6'd63, {16'h0000, 16'h0000, 16'hFFC1}); // R6 wrap to 0
    do_req(1, 2'd1, 3'd5, 6'd63, {16'h0000, 16'h0010, 16'h0000}); // R7 wrap below 0
    do_req(1, 2'd2, 3'd6, 6'd9,  {16'hBEEF, 16'h0000, 16'h0000}); // R8
    do_req(1, 2'd3, 3'd1, 6'd1,  {16'h1, 16'h2, 16'h3});          // R11 bad select
    do_req(1, 2'd0, 3'd7, 6'd1,  {16'h1, 16'h2, 16'h3});          // R11 op 7
    do_req(1, 2'd1, 3'd0, 6'd44, {16'h00FF, 16'hABCD, 16'h0});    // R2 ignores imm
    do_req(1, 2'd2, 3'd4, 6'd1,  {16'h00FF, 16'h0, 16'h0});       // R6 carry into high byte

    for (int n = 0; n < 3000; n++) begin
      do_req(($urandom % 8) != 0, 2'($urandom), 3'($urandom), 6'($urandom),
             {$urandom, $urandom});
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule